// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Register File

This block is the processor-facing register file of a three-channel interval timer. A host reaches it through a two-bit port address, an 8-bit write bus and an 8-bit read bus. Ports 0 to 2 reach the count registers of channels 0 to 2. Port 3 accepts control words. A control word either reprograms one channel or asks that channel to take a snapshot of its running count.

Each channel holds a 16-bit down counter. The counter runs from a reload value that the host writes one byte at a time, and it restarts from that value after each terminal count. A snapshot can be read back in one or two byte reads while the counter keeps running. The counting-mode field and the decimal-count flag are only stored and shown on outputs; the waveform logic behind them lives elsewhere. With the usual 1193182 Hz timer clock, a tone or tick rate f needs the reload value round(1193182 / f).

Top module: `tmr_host_regs`

## Requirements
- R1: After a synchronous reset, `rdata`, `tc`, `ch_mode` and `ch_bcd` are all zero and every counter is idle at 0. Reset leaves every channel in low-then-high byte access.
- R2: A write to port 3 is a control word. Bits 7:6 pick the channel (00, 01 or 10), bits 5:4 the byte access, bits 3:1 the counting mode and bit 0 the decimal flag. For access values other than 00, the mode appears on `ch_mode[3c+2:3c]` and the flag on `ch_bcd[c]` one clock later. A word with bits 7:6 = 11 changes nothing.
- R3: With access 11, the first data write to a channel port is the low byte and the second is the high byte. The reload value changes only once the high byte is written. The counter loads it on the following clock and then counts down by one on every clock.
- R4: With access 01, one write sets the reload value to {8'h00, byte}, and a read returns bits 7:0. With access 10, one write sets it to {byte, 8'h00}, and a read returns bits 15:8.
- R5: Take a reload value N. If the counter holds 1 at a clock edge, it reloads N at that edge, and `tc[c]` is high for exactly that one following cycle. Pulses therefore repeat every N clocks.
- R6: A reload value of 0 acts as 65536. The counter wraps to 0xFFFF and raises no terminal pulse for 65536 clocks.
- R7: A control word with access 00 makes that channel capture its current count. Later reads of the port return the captured value even while the counter keeps running. The stored mode, flag and access of the channel stay as they were.
- R8: A capture stays held until all of its bytes have been read under the current access: two reads for access 11, one read otherwise. Further capture commands to that channel are ignored until then.
- R9: A data write to a channel port is ignored while that channel holds a capture.
- R10: A control word with access other than 00 stops its channel. The counter holds its value, and the write and read byte toggles return to low. Counting resumes only once a full new reload value has been written.
- R11: A read drives `rdata` one clock after `rd_en`. Without a capture, a channel port returns the live count as it stood just before that edge, with the same byte sequencing as R4 and R3. Port 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | 2 | Port select: 0 to 2 channel count ports, 3 control port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| tc | output | 3 | One-clock terminal-count pulse per channel |
| ch_mode | output | 9 | Stored counting mode, three bits per channel |
| ch_bcd | output | 3 | Stored decimal-count flag per channel |

## Verification
The bench writes the low byte of a pair, then reprograms the channel, then writes a fresh pair. A design that forgot to clear the byte toggle would take the new low byte as a high byte and read back a value near 0x10AA. It issues a second capture before the first has been fully read, and reads the two halves of a capture forty clocks apart. A design that re-captured, or that read the live counter, would return a torn or later value. Each captured value is compared with the exact count predicted from the clock on which the reload finished. An off-by-one in the load or decrement pipeline therefore shows up directly, as does a write that slips through during a capture, a reload of zero that stops the counter, or a terminal pulse that is early, wide or missing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Byte access selected by control word bits 5:4
  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_PAIR = 2'b11
  } acc_e;

  // Control word layout, MSB first: channel, access, mode, decimal flag
  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_word_t;

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output tmr_pkg::ctl_word_t  ctl,
  output logic [NUM_CH-1:0]   ctl_we,
  output logic [NUM_CH-1:0]   latch_req,
  output logic [NUM_CH-1:0]   data_we,
  output logic [NUM_CH-1:0]   data_re
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] CTL_PORT = ADDR_W'(NUM_CH);

  logic ctl_hit;

  assign ctl     = ctl_word_t'(wdata[7:0]);
  assign ctl_hit = wr_en && (addr == CTL_PORT);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic chan_sel;
    assign chan_sel     = ctl_hit && (ctl.sel == 2'(c));
    assign ctl_we[c]    = chan_sel && (ctl.acc != ACC_SNAP);
    assign latch_req[c] = chan_sel && (ctl.acc == ACC_SNAP);
    assign data_we[c]   = wr_en && (addr == ADDR_W'(c));
    assign data_re[c]   = rd_en && (addr == ADDR_W'(c));
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic               latch_req,
  input  logic               data_we,
  input  logic               data_re,
  input  tmr_pkg::ctl_word_t ctl,
  input  logic [BYTE_W-1:0]  wbyte,
  output logic [BYTE_W-1:0]  rbyte,
  output logic [2:0]         mode_o,
  output logic               bcd_o,
  output logic               tc_o
);
  import tmr_pkg::*;

  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q;
  logic [CNT_W-1:0]  reload_q;
  logic [BYTE_W-1:0] stage_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  snap_q;
  logic              wr_hi_q;
  logic              rd_hi_q;
  logic              latched_q;
  logic              pend_q;
  logic              run_q;
  logic              tc_q;

  logic              wr_ok;
  logic              load_done;
  logic [CNT_W-1:0]  rd_src;

  // Data writes are blocked while a capture is held
  assign wr_ok     = data_we && !latched_q;
  assign load_done = wr_ok && ((acc_q != ACC_PAIR) || wr_hi_q);

  // Stored control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= ACC_PAIR;
      mode_q <= '0;
      bcd_q  <= 1'b0;
    end else if (ctl_we) begin
      acc_q  <= ctl.acc;
      mode_q <= ctl.mode;
      bcd_q  <= ctl.bcd;
    end
  end

  // Byte-sequenced reload value
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      stage_q  <= '0;
      wr_hi_q  <= 1'b0;
    end else if (ctl_we) begin
      wr_hi_q <= 1'b0;
    end else if (wr_ok) begin
      unique case (acc_q)
        ACC_LO: reload_q <= {{HI_W{1'b0}}, wbyte};
        ACC_HI: reload_q <= {wbyte[HI_W-1:0], {BYTE_W{1'b0}}};
        default: begin
          if (!wr_hi_q) begin
            stage_q <= wbyte;
            wr_hi_q <= 1'b1;
          end else begin
            reload_q <= {wbyte[HI_W-1:0], stage_q};
            wr_hi_q  <= 1'b0;
          end
        end
      endcase
    end
  end

  // Down counter with reload at terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (ctl_we) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (pend_q) begin
          count_q <= reload_q;
          run_q   <= 1'b1;
          pend_q  <= 1'b0;
        end else if (run_q) begin
          if (count_q == ONE) begin
            count_q <= reload_q;
            tc_q    <= 1'b1;
          end else begin
            count_q <= count_q - ONE;
          end
        end
        if (load_done) pend_q <= 1'b1;
      end
    end
  end

  // Capture and read-side byte toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q    <= '0;
      latched_q <= 1'b0;
      rd_hi_q   <= 1'b0;
    end else if (latch_req) begin
      if (!latched_q) begin
        snap_q    <= count_q;
        latched_q <= 1'b1;
        rd_hi_q   <= 1'b0;
      end
    end else if (ctl_we) begin
      rd_hi_q <= 1'b0;
    end else if (data_re) begin
      if ((acc_q == ACC_PAIR) && !rd_hi_q) begin
        rd_hi_q <= 1'b1;
      end else begin
        rd_hi_q   <= 1'b0;
        latched_q <= 1'b0;
      end
    end
  end

  assign rd_src = latched_q ? snap_q : count_q;

  always_comb begin
    unique case (acc_q)
      ACC_HI:   rbyte = BYTE_W'(rd_src[CNT_W-1:BYTE_W]);
      ACC_PAIR: rbyte = rd_hi_q ? BYTE_W'(rd_src[CNT_W-1:BYTE_W])
                                : rd_src[BYTE_W-1:0];
      default:  rbyte = rd_src[BYTE_W-1:0];
    endcase
  end

  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;
  assign tc_o   = tc_q;

  // R5: a terminal pulse coincides with the counter restarting at the reload value
  assert_tc_reload_R5: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (count_q == reload_q) || pend_q);

  // R3: a running counter away from terminal count drops by exactly one
  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && !pend_q && !ctl_we && (count_q != ONE)) |=> (count_q == $past(count_q) - ONE));

  // R7: a held capture does not move until it is read out
  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (latched_q && !data_re) |=> $stable(snap_q) && latched_q);

  // R9: data writes during a capture leave the reload path untouched
  assert_wr_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (latched_q && data_we && !ctl_we) |=> $stable(reload_q) && $stable(wr_hi_q));

  // R10: reprogramming halts the counter
  assert_stop_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> !run_q && !pend_q);

endmodule

// File: rtl/tmr_read_port.sv
module tmr_read_port #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*BYTE_W-1:0] rbytes,
  output logic [BYTE_W-1:0]        rdata
);
  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-1:0] rdata_q;

  always_comb begin
    sel_byte = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(c)) sel_byte = rbytes[c*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel_byte;
  end

  assign rdata = rdata_q;

  // R11: the control port always reads back as zero
  assert_ctl_port_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADDR_W'(NUM_CH))) |=> (rdata_q == '0));

endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  output logic [NUM_CH-1:0]   tc,
  output logic [3*NUM_CH-1:0] ch_mode,
  output logic [NUM_CH-1:0]   ch_bcd
);
  import tmr_pkg::*;

  ctl_word_t                ctl;
  logic [NUM_CH-1:0]        ctl_we;
  logic [NUM_CH-1:0]        latch_req;
  logic [NUM_CH-1:0]        data_we;
  logic [NUM_CH-1:0]        data_re;
  logic [NUM_CH*BYTE_W-1:0] rbytes;

  tmr_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .ctl       (ctl),
    .ctl_we    (ctl_we),
    .latch_req (latch_req),
    .data_we   (data_we),
    .data_re   (data_re)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tmr_channel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .ctl_we    (ctl_we[c]),
      .latch_req (latch_req[c]),
      .data_we   (data_we[c]),
      .data_re   (data_re[c]),
      .ctl       (ctl),
      .wbyte     (wdata),
      .rbyte     (rbytes[c*BYTE_W +: BYTE_W]),
      .mode_o    (ch_mode[3*c +: 3]),
      .bcd_o     (ch_bcd[c]),
      .tc_o      (tc[c])
    );
  end

  tmr_read_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .rbytes (rbytes),
    .rdata  (rdata)
  );

  // R2: a control word naming channel 3 leaves every stored field alone
  assert_bad_sel_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(NUM_CH)) && (wdata[7:6] == 2'b11))
      |=> $stable(ch_mode) && $stable(ch_bcd));

  // R7: a capture command leaves stored mode and flag alone
  assert_latch_keeps_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(NUM_CH)) && (wdata[5:4] == 2'b00))
      |=> $stable(ch_mode) && $stable(ch_bcd));

endmodule

// File: tb/test_tmr_host_regs.sv
module test_tmr_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {control word, expected ch_mode, expected ch_bcd}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h36, 9'b000_000_011, 3'b000},
    {8'h75, 9'b000_010_011, 3'b010},
    {8'hBB, 9'b101_010_011, 3'b110},
    {8'hFE, 9'b101_010_011, 3'b110},
    {8'h80, 9'b101_010_011, 3'b110},
    {8'h12, 9'b101_010_001, 3'b110}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] tc;
  logic [8:0] ch_mode;
  logic [2:0] ch_bcd;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tmr_host_regs i_tmr_host_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tc(tc), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // Expected count just before clock edge l, reload n finished at edge e
  function automatic logic [15:0] exp_cnt(input int n, input int l, input int e);
    return 16'((n - (l - e - 2)) & 32'hFFFF);
  endfunction

  // All bus tasks start and end at a falling edge
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, output int e);
    e = cyc + 1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output int e);
    e = cyc + 1;
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    int e;
    bus_rd(a, lo, e);
    bus_rd(a, hi, e);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int e, l, l2, s, t0;
    int first, second, npulse;
    logic [7:0] b, lo, hi;
    logic [15:0] v, v2;

    idle(3);
    rst = 1'b0;
    // R1: reset state
    check("R1 rdata", 32'(rdata), 0);
    check("R1 tc", 32'(tc), 0);
    check("R1 mode", 32'(ch_mode), 0);
    check("R1 bcd", 32'(ch_bcd), 0);
    rd16(2'd0, v);
    check("R1 idle count", 32'(v), 0);

    // R2: control word field table
    for (int i = 0; i < NVEC; i++) begin
      bus_wr(2'd3, VEC[i][19:12], e);
      check("R2 mode", 32'(ch_mode), 32'(VEC[i][11:3]));
      check("R2 bcd", 32'(ch_bcd), 32'(VEC[i][2:0]));
    end
    do_reset();

    // R3: low-then-high load on channel 0, N = 1000
    bus_wr(2'd3, 8'h34, e);
    bus_wr(2'd0, 8'hE8, e);
    bus_wr(2'd0, 8'h03, e);
    idle(20);
    bus_wr(2'd3, 8'h00, l);
    rd16(2'd0, v);
    check("R3 count after load", 32'(v), 32'(exp_cnt(1000, l, e)));

    // R7: capture stays while the counter runs; mode untouched
    bus_wr(2'd3, 8'h00, l);
    check("R7 mode kept", 32'(ch_mode[2:0]), 2);
    bus_rd(2'd0, lo, s);
    idle(40);
    bus_rd(2'd0, hi, s);
    check("R7 snapshot held", 32'({hi, lo}), 32'(exp_cnt(1000, l, e)));

    // R8: second capture before readout is ignored
    bus_wr(2'd3, 8'h00, l);
    idle(3);
    bus_wr(2'd3, 8'h00, l2);
    rd16(2'd0, v);
    check("R8 first capture kept", 32'(v), 32'(exp_cnt(1000, l, e)));
    bus_wr(2'd3, 8'h00, l2);
    rd16(2'd0, v);
    check("R8 new capture after readout", 32'(v), 32'(exp_cnt(1000, l2, e)));

    // R9: data write during a capture is dropped
    bus_wr(2'd3, 8'h00, l);
    bus_wr(2'd0, 8'h05, s);
    rd16(2'd0, v);
    check("R9 capture intact", 32'(v), 32'(exp_cnt(1000, l, e)));
    idle(5);
    bus_wr(2'd3, 8'h00, l);
    rd16(2'd0, v);
    check("R9 reload unchanged", 32'(v), 32'(exp_cnt(1000, l, e)));

    // R11: live reads and the control port
    bus_rd(2'd0, lo, l);
    check("R11 live low", 32'(lo), 32'(exp_cnt(1000, l, e) & 16'h00FF));
    bus_rd(2'd0, hi, l);
    check("R11 live high", 32'(hi), 32'(exp_cnt(1000, l, e) >> 8));
    bus_rd(2'd3, b, l);
    check("R11 control port reads zero", 32'(b), 0);

    // R10: reprogramming stops the counter
    bus_wr(2'd3, 8'h34, s);
    idle(5);
    bus_wr(2'd3, 8'h00, l);
    rd16(2'd0, v);
    idle(10);
    bus_wr(2'd3, 8'h00, l);
    rd16(2'd0, v2);
    check("R10 stopped value", 32'(v), 32'(exp_cnt(1000, s, e)));
    check("R10 stays stopped", 32'(v2), 32'(v));

    // R10: byte toggle cleared by a new control word (channel 1)
    bus_wr(2'd3, 8'h70, s);
    bus_wr(2'd1, 8'hAA, s);
    bus_wr(2'd3, 8'h70, s);
    bus_wr(2'd1, 8'h10, e);
    bus_wr(2'd1, 8'h00, e);
    idle(5);
    bus_wr(2'd3, 8'h40, l);
    rd16(2'd1, v);
    check("R10 toggle reset", 32'(v), 32'(exp_cnt(16, l, e)));

    // R4: high-byte-only and low-byte-only access on channel 1
    bus_wr(2'd3, 8'h60, s);
    bus_wr(2'd1, 8'h12, e);
    idle(8);
    bus_wr(2'd3, 8'h40, l);
    bus_rd(2'd1, b, s);
    check("R4 high-only byte", 32'(b), 32'(exp_cnt(16'h1200, l, e) >> 8));
    bus_wr(2'd3, 8'h50, s);
    bus_wr(2'd1, 8'h34, e);
    idle(8);
    bus_wr(2'd3, 8'h40, l);
    bus_rd(2'd1, b, s);
    check("R4 low-only byte", 32'(b), 32'(exp_cnt(16'h34, l, e) & 16'h00FF));
    bus_wr(2'd3, 8'h40, l);
    bus_rd(2'd1, b, s);
    check("R4 single read releases capture", 32'(b), 32'(exp_cnt(16'h34, l, e) & 16'h00FF));

    // R5: terminal pulse timing with N = 5 on channel 0
    bus_wr(2'd3, 8'h14, s);
    bus_wr(2'd0, 8'h05, e);
    first = -1; second = -1; npulse = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (tc[0]) begin
        npulse++;
        if (first < 0) first = cyc;
        else if (second < 0) second = cyc;
      end
    end
    check("R5 first pulse cycle", 32'(first - e), 6);
    check("R5 period", 32'(second - first), 5);
    check("R5 pulse count in window", 32'(npulse), 2);

    // R6: reload of zero on channel 2
    bus_wr(2'd3, 8'hB0, s);
    bus_wr(2'd2, 8'h00, e);
    bus_wr(2'd2, 8'h00, e);
    idle(10);
    bus_wr(2'd3, 8'h80, l);
    rd16(2'd2, v);
    check("R6 wraps through 0xFFFF", 32'(v), 32'(exp_cnt(65536, l, e)));
    t0 = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (tc[2]) t0++;
    end
    check("R6 no early terminal pulse", 32'(t0), 0);

    done = 1'b1;
    finish_run();
  end

endmodule